// File: doc/BRIEF.md
# Grouped Interrupt Expander with Vectoring

The block sits between 96 single-cycle peripheral interrupt pulses and a CPU that has only 12 interrupt inputs. The lines are split into 12 groups of 8. Each line latches its pulse into a flag, and each line has an enable. A group raises its CPU interrupt while any of its lines is both flagged and enabled, unless the group is waiting for software to acknowledge an earlier delivery.

When the CPU takes an interrupt, it strobes the fetch port with the group number. The block answers one cycle later with a 7-bit vector index for the highest-priority pending line of that group. It clears that line's flag and blocks the group until software writes its acknowledge bit. A software trap request numbered 1 to 12 maps to the first line of the matching group. A trap number that has no vector returns an error pulse instead of an index.

Only 58 of the 96 line positions are wired to sources. The rest are tied inactive inside the block.

Top module: `grp_irq_expander`

## Requirements
- R1: A one-cycle pulse on `irq_pulse_i[(g-1)*8+(l-1)]` sets the flag of line l in group g, and the flag stays set. Register map, data bit l-1 = line l: address g-1 (0..11) holds the enables of group g (read/write); address 11+g (12..23) holds the flags of group g, which are read-only, so writes to them have no effect; address 24 holds the acknowledge bits, bit g-1 = group g; address 25 bit 0 is the master enable. Reads are combinational.
- R2: Only these line positions are connected: lines 1..5 of groups 1..11, and lines 1..3 of group 12 (58 lines). A pulse on any other position never sets a flag.
- R3: `cpu_irq_o[g-1]` is high exactly when the master enable is set, group g has at least one line with flag and enable both set, and the acknowledge bit of group g is clear. It reflects a flag set on the clock edge that captures the pulse.
- R4: A fetch strobe with group number g in 1..12, while that group has a pending enabled line, makes `vec_valid_o` high on the next cycle with `vec_idx_o` = (g-1)*8 + (l-1). Here l is the lowest-numbered pending line, so line 1 has the highest priority. A fetch for group 0, for a group above 12, or for a group with nothing pending returns no vector and changes no state.
- R5: A fetch that returns a vector clears that line's flag and sets the group's acknowledge bit. The group's CPU line then stays low until the acknowledge bit is cleared.
- R6: If a new pulse arrives on the line that a fetch clears in the same cycle, the flag remains set.
- R7: A trap request with number n in 1..12 returns `vec_valid_o` with index (n-1)*8 on the next cycle. It leaves all flags and acknowledge bits unchanged.
- R8: A trap request with number 0 or above 12 pulses `trap_err_o` for one cycle on the next cycle and returns no vector.
- R9: In a cycle where `fetch_i` is high, a trap request is ignored.
- R10: With the master enable clear, all CPU lines are low, and fetch and trap requests produce no output and change no state. Flags still latch pulses.
- R11: After reset, all flags, enables, acknowledge bits and the master enable are 0, and `vec_valid_o`, `trap_err_o` and `cpu_irq_o` are low.
- R12: Writing address 24 clears each acknowledge bit whose data bit is 1 and leaves the bits written with 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pulse_i | input | 96 | Peripheral interrupt pulses, bit (g-1)*8+(l-1) for group g, line l |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 12 | Register write data |
| reg_rdata_o | output | 12 | Register read data |
| cpu_irq_o | output | 12 | CPU interrupt lines, bit g-1 for group g |
| fetch_i | input | 1 | Vector fetch strobe |
| fetch_grp_i | input | 4 | Group number of the fetch, 1..12 |
| trap_i | input | 1 | Trap request strobe |
| trap_num_i | input | 4 | Trap number |
| vec_valid_o | output | 1 | Vector index valid, one cycle after the request |
| vec_idx_o | output | 7 | Vector index |
| trap_err_o | output | 1 | Illegal trap number, one cycle after the request |

## Verification
The hardest case to reach is a new pulse landing on the very line that a fetch picks and clears in the same cycle. Random traffic almost never lines the two up. The bench first loads a known flag into one group, then in a single cycle both strobes the fetch for that group and pulses the same line, and reads the flag back through the register port. A second case needs an exact setup: a fetch with an out-of-range group number issued together with a trap. It is driven directly, to show that the fetch strobe alone blocks the trap. Random phases mix sparse pulses, fetches, traps, acknowledge writes and enable changes against a bench model of flags, enables and acknowledge bits.

// File: rtl/gie_pkg.sv
package gie_pkg;
  localparam int unsigned GRP_N_DEF  = 12;
  localparam int unsigned LINE_N_DEF = 8;

  typedef enum logic [1:0] {
    VEC_NONE,
    VEC_FETCH,
    VEC_TRAP,
    VEC_ERR
  } vec_kind_e;

  // wired positions: lines 1..5 of every group, only 1..3 in the last one
  function automatic logic [GRP_N_DEF*LINE_N_DEF-1:0] conn_mask_def();
    logic [GRP_N_DEF*LINE_N_DEF-1:0] m;
    m = '0;
    for (int g = 0; g < int'(GRP_N_DEF); g++) begin
      for (int k = 0; k < int'(LINE_N_DEF); k++) begin
        if (k < 5 && !(g == int'(GRP_N_DEF) - 1 && k >= 3)) m[g*LINE_N_DEF+k] = 1'b1;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/gie_group.sv
module gie_group #(
  parameter int unsigned LINE_N = 8,
  parameter logic [LINE_N-1:0] CONN = '1,
  localparam int unsigned SEL_W = (LINE_N > 1) ? $clog2(LINE_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_N-1:0] pulse_i,
  input  logic              en_we_i,
  input  logic [LINE_N-1:0] en_wdata_i,
  input  logic              take_i,
  input  logic              ack_i,
  input  logic              master_en_i,
  output logic [LINE_N-1:0] flag_o,
  output logic [LINE_N-1:0] en_o,
  output logic              pend_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              irq_o
);
  logic [LINE_N-1:0] en_q;
  logic [LINE_N-1:0] act;
  logic [LINE_N-1:0] clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  assign en_o   = en_q;
  assign act    = flag_o & en_q;
  assign pend_o = |act;

  // lowest line number wins
  always_comb begin
    sel_o = '0;
    for (int k = int'(LINE_N) - 1; k >= 0; k--) begin
      if (act[k]) sel_o = SEL_W'(k);
    end
  end

  always_comb begin
    clr = '0;
    if (take_i) clr[sel_o] = 1'b1;
  end

  for (genvar k = 0; k < int'(LINE_N); k++) begin : g_line
    if (CONN[k]) begin : g_conn
      logic flag_q;
      // set has priority over fetch clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         flag_q <= 1'b0;
        else if (pulse_i[k]) flag_q <= 1'b1;
        else if (clr[k])     flag_q <= 1'b0;
      end
      assign flag_o[k] = flag_q;
    end else begin : g_tie
      assign flag_o[k] = pulse_i[k] & 1'b0;
    end
  end

  assign irq_o = master_en_i & pend_o & ~ack_i;
endmodule

// File: rtl/gie_vector.sv
module gie_vector
  import gie_pkg::*;
#(
  parameter int unsigned GRP_N  = 12,
  parameter int unsigned LINE_N = 8,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned VEC_W  = 7
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        master_en_i,
  input  logic                        fetch_i,
  input  logic [GRP_W-1:0]            fetch_grp_i,
  input  logic                        trap_i,
  input  logic [GRP_W-1:0]            trap_num_i,
  input  logic [GRP_N-1:0]            pend_i,
  input  logic [GRP_N-1:0][SEL_W-1:0] sel_i,
  output logic [GRP_N-1:0]            take_o,
  output logic                        vec_valid_o,
  output logic [VEC_W-1:0]            vec_idx_o,
  output logic                        trap_err_o
);
  vec_kind_e        kind;
  logic [GRP_W-1:0] fg, tg;
  logic [VEC_W-1:0] idx_d;

  assign fg = fetch_grp_i - 1'b1;
  assign tg = trap_num_i - 1'b1;

  always_comb begin
    kind   = VEC_NONE;
    take_o = '0;
    idx_d  = '0;
    if (master_en_i) begin
      if (fetch_i) begin
        if (fetch_grp_i != '0 && int'(fetch_grp_i) <= int'(GRP_N)) begin
          if (pend_i[fg]) begin
            kind       = VEC_FETCH;
            take_o[fg] = 1'b1;
            idx_d      = VEC_W'(int'(fg) * int'(LINE_N) + int'(sel_i[fg]));
          end
        end
      end else if (trap_i) begin
        if (trap_num_i != '0 && int'(trap_num_i) <= int'(GRP_N)) begin
          kind  = VEC_TRAP;
          idx_d = VEC_W'(int'(tg) * int'(LINE_N));
        end else begin
          kind = VEC_ERR;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      trap_err_o  <= 1'b0;
      vec_idx_o   <= '0;
    end else begin
      vec_valid_o <= (kind == VEC_FETCH) || (kind == VEC_TRAP);
      trap_err_o  <= (kind == VEC_ERR);
      if (kind == VEC_FETCH || kind == VEC_TRAP) vec_idx_o <= idx_d;
    end
  end
endmodule

// File: rtl/gie_csr.sv
module gie_csr #(
  parameter int unsigned GRP_N  = 12,
  parameter int unsigned LINE_N = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         reg_we_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  input  logic [GRP_N-1:0][LINE_N-1:0] flag_i,
  input  logic [GRP_N-1:0][LINE_N-1:0] en_i,
  input  logic [GRP_N-1:0]             take_i,
  output logic [GRP_N-1:0]             en_we_o,
  output logic [GRP_N-1:0]             ack_o,
  output logic                         master_en_o,
  output logic [DATA_W-1:0]            reg_rdata_o
);
  localparam int unsigned ADDR_FLAG = GRP_N;
  localparam int unsigned ADDR_ACK  = 2 * GRP_N;
  localparam int unsigned ADDR_CTRL = 2 * GRP_N + 1;

  logic [GRP_N-1:0] ack_q, w1c;
  logic             ctrl_q;

  assign w1c = (reg_we_i && reg_addr_i == ADDR_W'(ADDR_ACK)) ? reg_wdata_i[GRP_N-1:0] : '0;

  // fetch setting an ack wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= '0;
    else         ack_q <= (ack_q & ~w1c) | take_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= 1'b0;
    else if (reg_we_i && reg_addr_i == ADDR_W'(ADDR_CTRL)) ctrl_q <= reg_wdata_i[0];
  end

  for (genvar g = 0; g < int'(GRP_N); g++) begin : g_we
    assign en_we_o[g] = reg_we_i && (reg_addr_i == ADDR_W'(g));
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int g = 0; g < int'(GRP_N); g++) begin
      if (reg_addr_i == ADDR_W'(g))             reg_rdata_o[LINE_N-1:0] = en_i[g];
      if (reg_addr_i == ADDR_W'(ADDR_FLAG + g)) reg_rdata_o[LINE_N-1:0] = flag_i[g];
    end
    if (reg_addr_i == ADDR_W'(ADDR_ACK))  reg_rdata_o[GRP_N-1:0] = ack_q;
    if (reg_addr_i == ADDR_W'(ADDR_CTRL)) reg_rdata_o[0] = ctrl_q;
  end

  assign ack_o       = ack_q;
  assign master_en_o = ctrl_q;
endmodule

// File: rtl/grp_irq_expander.sv
module grp_irq_expander
  import gie_pkg::*;
#(
  parameter int unsigned GRP_N  = GRP_N_DEF,
  parameter int unsigned LINE_N = LINE_N_DEF,
  parameter logic [GRP_N*LINE_N-1:0] CONN_MASK = conn_mask_def(),
  localparam int unsigned LINES  = GRP_N * LINE_N,
  localparam int unsigned VEC_W  = $clog2(LINES),
  localparam int unsigned GRP_W  = $clog2(GRP_N + 1),
  localparam int unsigned SEL_W  = (LINE_N > 1) ? $clog2(LINE_N) : 1,
  localparam int unsigned ADDR_W = $clog2(2 * GRP_N + 2),
  localparam int unsigned DATA_W = (GRP_N > LINE_N) ? GRP_N : LINE_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  irq_pulse_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [GRP_N-1:0]  cpu_irq_o,
  input  logic              fetch_i,
  input  logic [GRP_W-1:0]  fetch_grp_i,
  input  logic              trap_i,
  input  logic [GRP_W-1:0]  trap_num_i,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_idx_o,
  output logic              trap_err_o
);
  logic [GRP_N-1:0][LINE_N-1:0] flag_a, en_a;
  logic [GRP_N-1:0][SEL_W-1:0]  sel_a;
  logic [GRP_N-1:0]             pend, take, ack, en_we;
  logic                         master_en;

  for (genvar g = 0; g < int'(GRP_N); g++) begin : g_grp
    gie_group #(
      .LINE_N(LINE_N),
      .CONN  (CONN_MASK[g*LINE_N +: LINE_N])
    ) u_grp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pulse_i    (irq_pulse_i[g*LINE_N +: LINE_N]),
      .en_we_i    (en_we[g]),
      .en_wdata_i (reg_wdata_i[LINE_N-1:0]),
      .take_i     (take[g]),
      .ack_i      (ack[g]),
      .master_en_i(master_en),
      .flag_o     (flag_a[g]),
      .en_o       (en_a[g]),
      .pend_o     (pend[g]),
      .sel_o      (sel_a[g]),
      .irq_o      (cpu_irq_o[g])
    );
  end

  gie_vector #(
    .GRP_N (GRP_N),
    .LINE_N(LINE_N),
    .SEL_W (SEL_W),
    .GRP_W (GRP_W),
    .VEC_W (VEC_W)
  ) u_vec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .master_en_i(master_en),
    .fetch_i    (fetch_i),
    .fetch_grp_i(fetch_grp_i),
    .trap_i     (trap_i),
    .trap_num_i (trap_num_i),
    .pend_i     (pend),
    .sel_i      (sel_a),
    .take_o     (take),
    .vec_valid_o(vec_valid_o),
    .vec_idx_o  (vec_idx_o),
    .trap_err_o (trap_err_o)
  );

  gie_csr #(
    .GRP_N (GRP_N),
    .LINE_N(LINE_N),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .flag_i     (flag_a),
    .en_i       (en_a),
    .take_i     (take),
    .en_we_o    (en_we),
    .ack_o      (ack),
    .master_en_o(master_en),
    .reg_rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/gie_checker.sv
module gie_checker #(
  parameter int unsigned GRP_N  = 12,
  parameter int unsigned LINE_N = 8,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned VEC_W  = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             master_en_i,
  input logic             fetch_i,
  input logic [GRP_W-1:0] fetch_grp_i,
  input logic             trap_i,
  input logic [GRP_W-1:0] trap_num_i,
  input logic [GRP_N-1:0] cpu_irq_o,
  input logic             vec_valid_o,
  input logic [VEC_W-1:0] vec_idx_o,
  input logic             trap_err_o
);
  assert_trap_bad_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_en_i && trap_i && !fetch_i && (trap_num_i == '0 || int'(trap_num_i) > int'(GRP_N)))
    |=> (trap_err_o && !vec_valid_o));

  assert_trap_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_err_o && vec_valid_o));

  assert_trap_vec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_en_i && trap_i && !fetch_i && trap_num_i != '0 && int'(trap_num_i) <= int'(GRP_N))
    |=> (vec_valid_o && int'(vec_idx_o) == (int'($past(trap_num_i)) - 1) * int'(LINE_N)));

  assert_fetch_grp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_en_i && fetch_i && fetch_grp_i != '0 && int'(fetch_grp_i) <= int'(GRP_N)
      && cpu_irq_o[fetch_grp_i - 1'b1])
    |=> (vec_valid_o && int'(vec_idx_o) / int'(LINE_N) == int'($past(fetch_grp_i)) - 1));

  assert_disabled_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_en_i |=> (!vec_valid_o && !trap_err_o));

  for (genvar g = 0; g < int'(GRP_N); g++) begin : g_ack
    assert_fetch_masks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (master_en_i && fetch_i && fetch_grp_i == GRP_W'(g + 1) && cpu_irq_o[g])
      |=> !cpu_irq_o[g]);
  end
endmodule

bind grp_irq_expander gie_checker #(
  .GRP_N (GRP_N),
  .LINE_N(LINE_N),
  .GRP_W (GRP_W),
  .VEC_W (VEC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .master_en_i(master_en),
  .fetch_i    (fetch_i),
  .fetch_grp_i(fetch_grp_i),
  .trap_i     (trap_i),
  .trap_num_i (trap_num_i),
  .cpu_irq_o  (cpu_irq_o),
  .vec_valid_o(vec_valid_o),
  .vec_idx_o  (vec_idx_o),
  .trap_err_o (trap_err_o)
);

// File: tb/sim_grp_irq_expander.sv
module sim_grp_irq_expander;
  localparam int CLK_P = 10;
  localparam int G = 12, L = 8, N = 96;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]  pulse = '0;
  logic          we = 1'b0;
  logic [4:0]    addr = '0;
  logic [11:0]   wdata = '0, rdata;
  logic [G-1:0]  cpu_irq;
  logic          fetch = 1'b0, trap = 1'b0;
  logic [3:0]    fgrp = '0, tnum = '0;
  logic          vv, terr;
  logic [6:0]    vidx;

  always #(CLK_P/2) clk = ~clk;

  grp_irq_expander u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_pulse_i(pulse),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_irq_o(cpu_irq), .fetch_i(fetch), .fetch_grp_i(fgrp),
    .trap_i(trap), .trap_num_i(tnum),
    .vec_valid_o(vv), .vec_idx_o(vidx), .trap_err_o(terr)
  );

  logic [N-1:0] m_flag = '0, m_en = '0, m_conn;
  logic [G-1:0] m_ack = '0;
  logic         m_ctl = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [N-1:0] f_conn();
    logic [N-1:0] m = '0;
    for (int g = 0; g < G; g++)
      for (int k = 0; k < L; k++)
        if (k < 5 && !(g == 11 && k >= 3)) m[g*L+k] = 1'b1;
    return m;
  endfunction

  function automatic logic [G-1:0] exp_irq();
    logic [G-1:0] r = '0;
    for (int g = 0; g < G; g++)
      r[g] = m_ctl && (|(m_flag[g*L +: L] & m_en[g*L +: L])) && !m_ack[g];
    return r;
  endfunction

  function automatic int exp_sel(int g);
    for (int k = 0; k < L; k++)
      if (m_flag[g*L+k] && m_en[g*L+k]) return k;
    return -1;
  endfunction

  function automatic int exp_rd(int a);
    if (a < 12) return int'(m_en[a*L +: L]);
    if (a < 24) return int'(m_flag[(a-12)*L +: L]);
    if (a == 24) return int'(m_ack);
    if (a == 25) return int'(m_ctl);
    return 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(logic [N-1:0] p, bit f, int fg, bit t, int tn, string req);
    logic [N-1:0] clr = '0;
    int e_valid = 0, e_idx = 0, e_err = 0, tg = -1;
    pulse = p; fetch = f; fgrp = 4'(fg); trap = t; tnum = 4'(tn);
    if (m_ctl) begin
      if (f) begin
        if (fg >= 1 && fg <= G) begin
          int s = exp_sel(fg - 1);
          if (s >= 0) begin
            e_valid = 1; e_idx = (fg - 1) * L + s; clr[e_idx] = 1'b1; tg = fg - 1;
          end
        end
      end else if (t) begin
        if (tn >= 1 && tn <= G) begin e_valid = 1; e_idx = (tn - 1) * L; end
        else e_err = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    m_flag = (m_flag & ~clr) | (p & m_conn);
    if (tg >= 0) m_ack[tg] = 1'b1;
    pulse = '0; fetch = 1'b0; trap = 1'b0;
    chk(req, "vec_valid", int'(vv), e_valid);
    if (e_valid != 0) chk(req, "vec_idx", int'(vidx), e_idx);
    chk(req, "trap_err", int'(terr), e_err);
    chk(req, "cpu_irq", int'(cpu_irq), int'(exp_irq()));
  endtask

  task automatic wr(int a, int d);
    we = 1'b1; addr = 5'(a); wdata = 12'(d);
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    if (a < 12) m_en[a*L +: L] = 8'(d);
    else if (a == 24) m_ack = m_ack & ~12'(d);
    else if (a == 25) m_ctl = d[0];
  endtask

  task automatic rd(int a, string req);
    addr = 5'(a);
    #1;
    chk(req, "reg_rdata", int'(rdata), exp_rd(a));
  endtask

  task automatic drain();
    for (int g = 1; g <= G; g++)
      for (int i = 0; i < L; i++) begin
        step('0, 1'b1, g, 1'b0, 0, "R4");
        wr(24, 12'hfff);
      end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_conn = f_conn();
    void'($urandom(32'd7321));
    #(CLK_P * 3);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11", "cpu_irq", int'(cpu_irq), 0);
    chk("R11", "vec_valid", int'(vv), 0);
    chk("R11", "trap_err", int'(terr), 0);
    for (int a = 0; a < 26; a++) rd(a, "R11");

    // R1 R2 R3: all lines pulse, only wired ones flag
    wr(25, 1);
    for (int g = 0; g < G; g++) wr(g, 8'hff);
    step('1, 1'b0, 0, 1'b0, 0, "R3");
    for (int a = 12; a < 24; a++) rd(a, "R2");
    chk("R2", "flag_count", $countones(m_flag), 58);
    // R1 flag registers are read-only
    wr(14, 12'h0ff);
    rd(14, "R1");
    chk("R1", "flag_grp3", exp_rd(14), 8'h1f);
    drain();

    // R4 priority, R5 masking, R12 W1C
    begin
      logic [N-1:0] p = '0;
      p[17] = 1'b1; p[20] = 1'b1;
      step(p, 1'b0, 0, 1'b0, 0, "R1");
    end
    chk("R3", "irq_grp3", int'(cpu_irq[2]), 1);
    step('0, 1'b1, 3, 1'b0, 0, "R4");
    chk("R4", "prio_idx", int'(vidx), 17);
    chk("R5", "irq_after_fetch", int'(cpu_irq[2]), 0);
    rd(14, "R5");
    wr(24, 12'hffb);
    chk("R12", "ack_kept", int'(cpu_irq[2]), 0);
    rd(24, "R12");
    wr(24, 12'h004);
    chk("R12", "ack_cleared", int'(cpu_irq[2]), 1);
    step('0, 1'b1, 3, 1'b0, 0, "R4");
    chk("R4", "second_idx", int'(vidx), 20);
    wr(24, 12'hfff);

    // R6 collision: set wins over fetch clear
    begin
      logic [N-1:0] p = '0;
      p[41] = 1'b1;
      step(p, 1'b0, 0, 1'b0, 0, "R6");
      step(p, 1'b1, 6, 1'b0, 0, "R6");
      chk("R6", "idx", int'(vidx), 41);
      rd(17, "R6");
      chk("R6", "flag_kept", exp_rd(17), 2);
    end
    wr(24, 12'hfff);

    // R7 R8 R9 traps
    step('0, 1'b0, 0, 1'b1, 0, "R8");
    step('0, 1'b0, 0, 1'b1, 12, "R7");
    chk("R7", "trap12_idx", int'(vidx), 88);
    rd(17, "R7");
    rd(24, "R7");
    step('0, 1'b0, 0, 1'b1, 13, "R8");
    step('0, 1'b1, 0, 1'b1, 5, "R9");
    step('0, 1'b1, 14, 1'b1, 0, "R9");

    // R3 enable masks a flagged line
    wr(5, 0);
    step('0, 1'b1, 6, 1'b0, 0, "R3");
    wr(5, 8'hff);

    // R10 master disable
    wr(25, 0);
    begin
      logic [N-1:0] p = '0;
      p[0] = 1'b1;
      step(p, 1'b0, 0, 1'b0, 0, "R10");
    end
    step('0, 1'b1, 1, 1'b0, 0, "R10");
    step('0, 1'b0, 0, 1'b1, 0, "R10");
    rd(12, "R10");
    rd(24, "R10");
    wr(25, 1);
    chk("R10", "irq_back", int'(cpu_irq[0]), 1);
    drain();

    // random mix
    for (int it = 0; it < 4000; it++) begin
      int r = int'($urandom % 8);
      if (r == 0) begin
        int w = int'($urandom % 4);
        if (w == 0)      wr(int'($urandom % 12), int'($urandom % 256));
        else if (w == 1) wr(24, int'($urandom % 4096));
        else if (w == 2) wr(25, ($urandom % 8) != 0);
        else             wr(12 + int'($urandom % 12), int'($urandom % 4096));
      end else begin
        logic [N-1:0] p = '0;
        for (int i = 0; i < N; i++) p[i] = ($urandom % 24) == 0;
        step(p, ($urandom % 2) == 1, int'($urandom % 14), ($urandom % 5) == 0,
             int'($urandom % 16), "R4");
      end
      if (it % 16 == 0) rd(int'($urandom % 26), "R1");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule